// File: doc/BRIEF.md
# Interrupt Pin Redirection Controller

This block collects a bank of external interrupt lines and turns each qualifying event on a line into a delivery message for a processor-side interrupt receiver. Every line owns a 64-bit routing entry that holds the vector, the delivery mode, whether the destination is physical or logical, the destination itself, the line's polarity and whether it is edge or level sensitive, and a mask. Lines have no built-in rank among themselves. The vector in each entry is what conveys urgency downstream. When several lines are waiting at once, a rotating pointer chooses which one is sent next.

Software reaches the table only through two bus offsets. The selector at offset 0x00 names an internal index, and the data window at offset 0x10 reads or writes the register at that index. The message leaves on a valid/ready handshake. A level-sensitive line that has delivered stays blocked until an end-of-interrupt notice arrives that carries the same vector.

Top module: `irq_redirect`

## Requirements
- R1: After reset no message is valid, and every entry reads back with its mask bit (bit 16 of the low word) set and all other low-word bits zero.
- R2: The bus selector sits at offset 0x00 and reads back its own value. The window sits at offset 0x10. Through the window, index 0x00 reads the fixed ID word (ID in bits 31:24), and index 0x01 reads a version word with 0x11 in bits 7:0 and the last entry number (23) in bits 23:16. Entry n occupies index 0x10+2n (low word) and 0x11+2n (high word).
- R3: The low word places the vector in bits 7:0, delivery mode in 10:8, destination mode in 11, polarity in 13 (1 = active low), trigger mode in 15 (1 = level) and mask in 16. The high word places the destination in bits 31:24. Bits 12 and 14 ignore writes, and unassigned bits read zero.
- R4: An edge-triggered line delivers exactly one message per inactive-to-active transition, where "active" takes the polarity bit into account. Holding the line active produces nothing more.
- R5: A message carries the vector, delivery mode, destination mode, destination and trigger mode of the entry of the line that raised it.
- R6: A line whose mask bit is set raises no message.
- R7: Delivery status (low-word bit 12) reads 1 from the moment a line's request is captured until its message is accepted, and 0 afterwards. While ready is low, the presented message stays valid and unchanged.
- R8: When a level-triggered line's message is accepted, remote-IRR (low-word bit 14) becomes 1. The line then raises nothing further while it stays active. An end-of-interrupt carrying a different vector leaves it blocked.
- R9: An end-of-interrupt whose vector matches a level entry clears that entry's remote-IRR. If the line is still active, it delivers again.
- R10: Among lines waiting at the same time, the search for the next message starts at the line after the one most recently granted and wraps around, so a lower line number does not win by itself.
- R11: If the message of a level line is accepted in the same cycle as a matching end-of-interrupt, the acceptance wins and remote-IRR ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | NUM_PINS | Interrupt lines |
| bus_we_i | input | 1 | Single-cycle write strobe |
| bus_addr_i | input | 5 | Byte offset: 0x00 selector, 0x10 window |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for the current offset (combinational) |
| msg_valid_o | output | 1 | Message is presented |
| msg_ready_i | input | 1 | Receiver takes the message |
| msg_vector_o | output | 8 | Vector |
| msg_dlv_mode_o | output | 3 | Delivery mode |
| msg_dst_logical_o | output | 1 | 1 = logical destination, 0 = physical unit ID |
| msg_dest_o | output | 8 | Destination |
| msg_level_o | output | 1 | 1 = level-triggered source |
| eoi_valid_i | input | 1 | End-of-interrupt strobe |
| eoi_vector_i | input | 8 | Vector being retired |

## Verification
The sharp collision is between message acceptance and an end-of-interrupt that targets the same level line. The bench holds ready low until that line's message is waiting. It then raises ready together with a matching end-of-interrupt in one cycle. The result is judged through remote-IRR in the window readback and by the absence of any repeat message over the following cycles. A second overlap, two lines asserting in the same cycle, is provoked twice with different pointer positions, and the logged vector order is checked against the rotation rule.

// File: rtl/irq_redir_pkg.sv
`timescale 1ns/1ps
package irq_redir_pkg;
  typedef struct packed {
    logic [7:0] dest;
    logic       mask;
    logic       level;
    logic       active_low;
    logic       dst_logical;
    logic [2:0] dlv_mode;
    logic [7:0] vector;
  } rte_t;

  typedef struct packed {
    logic [7:0] dest;
    logic       level;
    logic       dst_logical;
    logic [2:0] dlv_mode;
    logic [7:0] vector;
  } msg_t;

  localparam logic [4:0] OFS_SEL  = 5'h00;
  localparam logic [4:0] OFS_WIN  = 5'h10;
  localparam logic [7:0] IDX_ID   = 8'h00;
  localparam logic [7:0] IDX_VER  = 8'h01;
  localparam int         IDX_TBL  = 16;
  localparam logic [7:0] VER_CODE = 8'h11;

  localparam rte_t RTE_RST = '{dest: 8'h00, mask: 1'b1, level: 1'b0, active_low: 1'b0,
                               dst_logical: 1'b0, dlv_mode: 3'd0, vector: 8'h00};
endpackage

// File: rtl/irq_reg_file.sv
`timescale 1ns/1ps
module irq_reg_file
  import irq_redir_pkg::*;
#(
  parameter int         NUM_PINS = 24,
  parameter logic [7:0] ID_VAL   = 8'h02
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  bus_we_i,
  input  logic [4:0]            bus_addr_i,
  input  logic [31:0]           bus_wdata_i,
  output logic [31:0]           bus_rdata_o,
  input  logic [NUM_PINS-1:0]   pend_i,
  input  logic [NUM_PINS-1:0]   rirr_i,
  output rte_t [NUM_PINS-1:0]   entries_o
);
  localparam logic [7:0] LAST_IDX = 8'(NUM_PINS - 1);

  logic [7:0] sel_q;
  logic       win_we;
  logic       unused_wd;

  assign win_we    = bus_we_i && (bus_addr_i == OFS_WIN);
  assign unused_wd = ^{bus_wdata_i[23:17], bus_wdata_i[14], bus_wdata_i[12]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                    sel_q <= '0;
    else if (bus_we_i && (bus_addr_i == OFS_SEL))   sel_q <= bus_wdata_i[7:0];
  end

  for (genvar n = 0; n < NUM_PINS; n++) begin : g_ent
    rte_t ent_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ent_q <= RTE_RST;
      end else if (win_we && (sel_q == 8'(IDX_TBL + 2*n))) begin
        ent_q.vector      <= bus_wdata_i[7:0];
        ent_q.dlv_mode    <= bus_wdata_i[10:8];
        ent_q.dst_logical <= bus_wdata_i[11];
        ent_q.active_low  <= bus_wdata_i[13];
        ent_q.level       <= bus_wdata_i[15];
        ent_q.mask        <= bus_wdata_i[16];
      end else if (win_we && (sel_q == 8'(IDX_TBL + 2*n + 1))) begin
        ent_q.dest        <= bus_wdata_i[31:24];
      end
    end
    assign entries_o[n] = ent_q;
  end

  always_comb begin
    bus_rdata_o = '0;
    if (bus_addr_i == OFS_SEL) begin
      bus_rdata_o = {24'h0, sel_q};
    end else if (bus_addr_i == OFS_WIN) begin
      if (sel_q == IDX_ID)  bus_rdata_o = {ID_VAL, 24'h0};
      if (sel_q == IDX_VER) bus_rdata_o = {8'h00, LAST_IDX, 8'h00, VER_CODE};
      for (int n = 0; n < NUM_PINS; n++) begin
        if (sel_q == 8'(IDX_TBL + 2*n))
          bus_rdata_o = {15'h0, entries_o[n].mask, entries_o[n].level, rirr_i[n],
                         entries_o[n].active_low, pend_i[n], entries_o[n].dst_logical,
                         entries_o[n].dlv_mode, entries_o[n].vector};
        if (sel_q == 8'(IDX_TBL + 2*n + 1))
          bus_rdata_o = {entries_o[n].dest, 24'h0};
      end
    end
  end
endmodule

// File: rtl/irq_pin_ctl.sv
`timescale 1ns/1ps
module irq_pin_ctl (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       irq_i,
  input  logic       act_low_i,
  input  logic       level_i,
  input  logic       mask_i,
  input  logic [7:0] vector_i,
  input  logic       acc_i,
  input  logic       eoi_valid_i,
  input  logic [7:0] eoi_vector_i,
  output logic       pend_o,
  output logic       rirr_o
);
  logic act, act_q, pend_q, rirr_q, fire;

  assign act  = irq_i ^ act_low_i;
  assign fire = !mask_i && act && (level_i ? (!rirr_q && !pend_q) : !act_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= 1'b0;
      pend_q <= 1'b0;
      rirr_q <= 1'b0;
    end else begin
      act_q  <= act;
      pend_q <= (pend_q && !acc_i) || fire;  // new request beats clear
      if (acc_i && level_i)                                   rirr_q <= 1'b1;
      else if (!level_i)                                      rirr_q <= 1'b0;
      else if (eoi_valid_i && (eoi_vector_i == vector_i))     rirr_q <= 1'b0;
    end
  end

  assign pend_o = pend_q;
  assign rirr_o = rirr_q;

  AST_ACC_NEEDS_PEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_i |-> pend_q); // R7
  AST_NO_ACC_BLOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rirr_q |-> !acc_i); // R8
  AST_ACC_SETS_RIRR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_i && level_i) |=> rirr_q); // R11
endmodule

// File: rtl/irq_msg_sel.sv
`timescale 1ns/1ps
module irq_msg_sel
  import irq_redir_pkg::*;
#(
  parameter int NUM_PINS = 24
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [NUM_PINS-1:0]   eligible_i,
  input  msg_t [NUM_PINS-1:0]   msgs_i,
  input  logic                  ready_i,
  output logic                  valid_o,
  output msg_t                  msg_o,
  output logic [NUM_PINS-1:0]   accept_o
);
  localparam int IDX_W = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1;

  logic             busy_q, found;
  logic [IDX_W-1:0] cur_q, ptr_q, pick;
  msg_t             msg_q;

  always_comb begin
    int j;
    found = 1'b0;
    pick  = '0;
    for (int k = 0; k < NUM_PINS; k++) begin
      j = int'(ptr_q) + k;
      if (j >= NUM_PINS) j = j - NUM_PINS;
      if (!found && eligible_i[j]) begin
        found = 1'b1;
        pick  = IDX_W'(j);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cur_q  <= '0;
      ptr_q  <= '0;
      msg_q  <= '0;
    end else if (busy_q) begin
      if (ready_i) busy_q <= 1'b0;
    end else if (found) begin
      busy_q <= 1'b1;
      cur_q  <= pick;
      msg_q  <= msgs_i[pick];
      ptr_q  <= (pick == IDX_W'(NUM_PINS - 1)) ? '0 : pick + 1'b1;
    end
  end

  always_comb begin
    accept_o = '0;
    if (busy_q && ready_i) accept_o[cur_q] = 1'b1;
  end

  assign valid_o = busy_q;
  assign msg_o   = msg_q;

  AST_MSG_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !ready_i) |=> (valid_o && $stable(msg_o))); // R7
  AST_GAP_AFTER_ACC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && ready_i) |=> !valid_o); // R10
endmodule

// File: rtl/irq_redirect.sv
`timescale 1ns/1ps
module irq_redirect
  import irq_redir_pkg::*;
#(
  parameter int         NUM_PINS = 24,
  parameter logic [7:0] ID_VAL   = 8'h02
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] irq_i,
  input  logic                bus_we_i,
  input  logic [4:0]          bus_addr_i,
  input  logic [31:0]         bus_wdata_i,
  output logic [31:0]         bus_rdata_o,
  output logic                msg_valid_o,
  input  logic                msg_ready_i,
  output logic [7:0]          msg_vector_o,
  output logic [2:0]          msg_dlv_mode_o,
  output logic                msg_dst_logical_o,
  output logic [7:0]          msg_dest_o,
  output logic                msg_level_o,
  input  logic                eoi_valid_i,
  input  logic [7:0]          eoi_vector_i
);
  rte_t [NUM_PINS-1:0] entries;
  msg_t [NUM_PINS-1:0] msgs;
  logic [NUM_PINS-1:0] pend, rirr, eligible, accept;
  msg_t                msg;

  irq_reg_file #(.NUM_PINS(NUM_PINS), .ID_VAL(ID_VAL)) u_regs (
    .clk_i, .rst_ni, .bus_we_i, .bus_addr_i, .bus_wdata_i, .bus_rdata_o,
    .pend_i(pend), .rirr_i(rirr), .entries_o(entries)
  );

  for (genvar n = 0; n < NUM_PINS; n++) begin : g_pin
    irq_pin_ctl u_pin (
      .clk_i, .rst_ni,
      .irq_i       (irq_i[n]),
      .act_low_i   (entries[n].active_low),
      .level_i     (entries[n].level),
      .mask_i      (entries[n].mask),
      .vector_i    (entries[n].vector),
      .acc_i       (accept[n]),
      .eoi_valid_i,
      .eoi_vector_i,
      .pend_o      (pend[n]),
      .rirr_o      (rirr[n])
    );
    assign eligible[n] = pend[n] && !entries[n].mask;
    assign msgs[n] = '{dest: entries[n].dest, level: entries[n].level,
                       dst_logical: entries[n].dst_logical,
                       dlv_mode: entries[n].dlv_mode, vector: entries[n].vector};
  end

  irq_msg_sel #(.NUM_PINS(NUM_PINS)) u_sel (
    .clk_i, .rst_ni,
    .eligible_i (eligible),
    .msgs_i     (msgs),
    .ready_i    (msg_ready_i),
    .valid_o    (msg_valid_o),
    .msg_o      (msg),
    .accept_o   (accept)
  );

  assign msg_vector_o      = msg.vector;
  assign msg_dlv_mode_o    = msg.dlv_mode;
  assign msg_dst_logical_o = msg.dst_logical;
  assign msg_dest_o        = msg.dest;
  assign msg_level_o       = msg.level;

  AST_RESET_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(msg_valid_o) |-> $past(|eligible)); // R6
endmodule

// File: tb/irq_redirect_bench.sv
`timescale 1ns/1ps
module irq_redirect_bench;
  localparam int N = 24;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [N-1:0] irq = '0;
  logic        we = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        mvalid, mready = 1'b0;
  logic [7:0]  mvec, mdest;
  logic [2:0]  mdlv;
  logic        mdst, mlvl;
  logic        eoi_v = 1'b0;
  logic [7:0]  eoi_vec = '0;

  int n_chk = 0, n_fail = 0;
  int msg_cnt = 0;
  int vcnt [256];
  logic [7:0] vlog [256];
  logic [7:0] exp_dest [256];
  bit  dest_chk_on [256];

  always #10 clk = ~clk;

  irq_redirect u_irq_redirect (
    .clk_i(clk), .rst_ni(rst_n), .irq_i(irq),
    .bus_we_i(we), .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .msg_valid_o(mvalid), .msg_ready_i(mready), .msg_vector_o(mvec),
    .msg_dlv_mode_o(mdlv), .msg_dst_logical_o(mdst), .msg_dest_o(mdest),
    .msg_level_o(mlvl), .eoi_valid_i(eoi_v), .eoi_vector_i(eoi_vec)
  );

  function automatic logic [31:0] mk_lo(input logic [7:0] vec, input logic [2:0] dlv,
      input logic dst, input logic pol, input logic lvl, input logic msk,
      input logic dstat, input logic rirr);
    return {15'h0, msk, lvl, rirr, pol, dstat, dst, dlv, vec};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic waitc(input int c);
    repeat (c) @(negedge clk);
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd_idx(input logic [7:0] idx, output logic [31:0] d);
    wr(5'h00, {24'h0, idx});
    addr = 5'h10; #1; d = rdata;
  endtask

  task automatic set_ent(input int p, input logic [31:0] lo, input logic [31:0] hi);
    wr(5'h00, 32'(16 + 2*p)); wr(5'h10, lo);
    wr(5'h00, 32'(17 + 2*p)); wr(5'h10, hi);
  endtask

  task automatic eoi(input logic [7:0] v);
    @(negedge clk); eoi_v = 1'b1; eoi_vec = v;
    @(negedge clk); eoi_v = 1'b0;
  endtask

  always @(posedge clk) begin
    if (rst_n && mvalid && mready) begin
      vlog[msg_cnt[7:0]] = mvec;
      msg_cnt++;
      vcnt[mvec]++;
      if (dest_chk_on[mvec]) begin
        n_chk++;
        if (mdest !== exp_dest[mvec]) begin
          n_fail++;
          $display("FAIL R5 dest actual=%h expected=%h", mdest, exp_dest[mvec]);
        end
      end
    end
  end

  initial begin
    #(20 * 150000);
    n_fail++;
    $display("FAIL watchdog actual=%h expected=%h", 0, 1);
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int base;
    int last_t [N];
    int exp_cnt [N];
    for (int i = 0; i < 256; i++) begin vcnt[i] = 0; dest_chk_on[i] = 1'b0; exp_dest[i] = '0; end
    void'($urandom(32'd20240));
    waitc(3);
    rst_n = 1'b1;
    waitc(2);

    // R1 reset state
    chk("R1 valid", 32'(mvalid), 0);
    rd_idx(8'h10, d); chk("R1 entry0", d, mk_lo(0, 0, 0, 0, 0, 1, 0, 0));
    rd_idx(8'h3E, d); chk("R1 entry23", d, mk_lo(0, 0, 0, 0, 0, 1, 0, 0));

    // R2 ID, version, selector readback
    rd_idx(8'h00, d); chk("R2 id", d, 32'h0200_0000);
    rd_idx(8'h01, d); chk("R2 version", d, 32'h0017_0011);
    wr(5'h00, 32'h18); addr = 5'h00; #1; chk("R2 select", rdata, 32'h18);

    // R3 layout, read-only bits
    set_ent(4, 32'hFFFF_7F23, 32'h5A12_3456);
    rd_idx(8'h18, d); chk("R3 low word", d, mk_lo(8'h23, 3'd7, 1, 1, 0, 1, 0, 0));
    rd_idx(8'h19, d); chk("R3 high word", d, 32'h5A00_0000);

    // R4/R5/R7 edge pin 2
    mready = 1'b0;
    set_ent(2, mk_lo(8'h31, 3'd1, 1, 0, 0, 0, 0, 0), 32'hA500_0000);
    @(negedge clk); irq[2] = 1'b1;
    waitc(2);
    chk("R5 valid", 32'(mvalid), 1);
    chk("R5 vector", 32'(mvec), 32'h31);
    chk("R5 dlv", 32'(mdlv), 1);
    chk("R5 dstmode", 32'(mdst), 1);
    chk("R5 dest", 32'(mdest), 32'hA5);
    chk("R5 trig", 32'(mlvl), 0);
    rd_idx(8'h14, d); chk("R7 status pending", d, mk_lo(8'h31, 3'd1, 1, 0, 0, 0, 1, 0));
    chk("R7 held valid", 32'(mvalid), 1);
    chk("R7 held vector", 32'(mvec), 32'h31);
    base = msg_cnt;
    @(negedge clk); mready = 1'b1;
    @(negedge clk);
    chk("R7 drop after accept", 32'(mvalid), 0);
    rd_idx(8'h14, d); chk("R7 status clear", d, mk_lo(8'h31, 3'd1, 1, 0, 0, 0, 0, 0));
    waitc(10);
    chk("R4 once while held", 32'(msg_cnt - base), 1);
    irq[2] = 1'b0; waitc(4); irq[2] = 1'b1; waitc(6);
    chk("R4 second edge", 32'(msg_cnt - base), 2);
    irq[2] = 1'b0;

    // R4 active-low pin 6
    irq[6] = 1'b1; waitc(2);
    base = msg_cnt;
    set_ent(6, mk_lo(8'h36, 0, 0, 1, 0, 0, 0, 0), 32'h0);
    waitc(4);
    chk("R4 pol idle", 32'(msg_cnt - base), 0);
    irq[6] = 1'b0; waitc(6);
    chk("R4 pol fire", 32'(msg_cnt - base), 1);
    chk("R4 pol vector", 32'(vlog[8'(msg_cnt - 1)]), 32'h36);
    irq[6] = 1'b1; waitc(6);
    chk("R4 pol release", 32'(msg_cnt - base), 1);

    // R6 masked pin 7
    base = msg_cnt;
    set_ent(7, mk_lo(8'h37, 0, 0, 0, 0, 1, 0, 0), 32'h0);
    irq[7] = 1'b1; waitc(4); irq[7] = 1'b0; waitc(4); irq[7] = 1'b1; waitc(6);
    chk("R6 masked silent", 32'(msg_cnt - base), 0);
    rd_idx(8'h1E, d); chk("R6 no pending", d, mk_lo(8'h37, 0, 0, 0, 0, 1, 0, 0));
    irq[7] = 1'b0;

    // R8/R9 level pin 9
    base = msg_cnt;
    set_ent(9, mk_lo(8'h55, 0, 0, 0, 1, 0, 0, 0), 32'h3300_0000);
    @(negedge clk); irq[9] = 1'b1;
    waitc(8);
    chk("R8 one message", 32'(msg_cnt - base), 1);
    rd_idx(8'h22, d); chk("R8 remote-irr set", d, mk_lo(8'h55, 0, 0, 0, 1, 0, 0, 1));
    eoi(8'h56); waitc(8);
    chk("R8 foreign eoi", 32'(msg_cnt - base), 1);
    eoi(8'h55); waitc(8);
    chk("R9 refire", 32'(msg_cnt - base), 2);
    rd_idx(8'h22, d); chk("R9 remote-irr again", d, mk_lo(8'h55, 0, 0, 0, 1, 0, 0, 1));
    irq[9] = 1'b0; eoi(8'h55); waitc(6);
    chk("R9 idle after eoi", 32'(msg_cnt - base), 2);
    rd_idx(8'h22, d); chk("R9 remote-irr clear", d, mk_lo(8'h55, 0, 0, 0, 1, 0, 0, 0));

    // R11 accept and matching EOI in one cycle
    base = msg_cnt;
    mready = 1'b0;
    @(negedge clk); irq[9] = 1'b1;
    waitc(4);
    chk("R11 waiting", 32'(mvec), 32'h55);
    mready = 1'b1; eoi_v = 1'b1; eoi_vec = 8'h55;
    @(negedge clk); eoi_v = 1'b0;
    waitc(10);
    chk("R11 single delivery", 32'(msg_cnt - base), 1);
    rd_idx(8'h22, d); chk("R11 remote-irr wins", d, mk_lo(8'h55, 0, 0, 0, 1, 0, 0, 1));
    irq[9] = 1'b0; eoi(8'h55);

    // R10 rotation: pointer sits after pin 9
    set_ent(0, mk_lo(8'h40, 0, 0, 0, 0, 0, 0, 0), 32'h0);
    set_ent(3, mk_lo(8'h43, 0, 0, 0, 0, 0, 0, 0), 32'h0);
    set_ent(5, mk_lo(8'h45, 0, 0, 0, 0, 0, 0, 0), 32'h0);
    set_ent(8, mk_lo(8'h48, 0, 0, 0, 0, 0, 0, 0), 32'h0);
    mready = 1'b0;
    @(negedge clk); irq[0] = 1'b1; irq[5] = 1'b1;
    waitc(4); base = msg_cnt; mready = 1'b1; waitc(6);
    chk("R10 first wrap", 32'(vlog[8'(base)]), 32'h40);
    chk("R10 second", 32'(vlog[8'(base + 1)]), 32'h45);
    mready = 1'b0; irq[0] = 1'b0; irq[5] = 1'b0;
    @(negedge clk); irq[3] = 1'b1; irq[8] = 1'b1;
    waitc(4); base = msg_cnt; mready = 1'b1; waitc(6);
    chk("R10 higher line first", 32'(vlog[8'(base)]), 32'h48);
    chk("R10 then lower", 32'(vlog[8'(base + 1)]), 32'h43);
    irq[3] = 1'b0; irq[8] = 1'b0; waitc(2);

    // random edge traffic on pins 12..19 (R4, R5)
    for (int p = 12; p < 20; p++) begin
      logic [7:0] dst;
      dst = 8'($urandom());
      exp_dest[8'(p + 'h54)] = dst;
      dest_chk_on[8'(p + 'h54)] = 1'b1;
      set_ent(p, mk_lo(8'(p + 'h54), 0, 0, 0, 0, 0, 0, 0), {dst, 24'h0});
      last_t[p] = 0;
      exp_cnt[p] = 0;
    end
    for (int t = 100; t < 3100; t++) begin
      @(negedge clk);
      mready = ($urandom() % 4) != 0;
      for (int p = 12; p < 20; p++) begin
        if ((t - last_t[p] >= 60) && ($urandom() % 8 == 0)) begin
          irq[p] = ~irq[p];
          last_t[p] = t;
          if (irq[p]) exp_cnt[p]++;
        end
      end
    end
    mready = 1'b1; waitc(60);
    for (int p = 12; p < 20; p++)
      chk("R4 random count", 32'(vcnt[8'(p + 'h54)]), 32'(exp_cnt[p]));

    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule